// File: doc/BRIEF.md
# Quad SPI Command Frame Master

This block is the host side of a four-line serial link to a flash-style target. A client asks for one of three operations (write one byte, read one byte, erase) by presenting an operation code, a 24-bit address and a data byte together with a valid strobe. The block then runs one complete frame on the serial pins and returns to idle.

Each frame begins with chip select going low. An opcode byte follows, then the address most significant byte first, and for writes the data byte. Every byte travels as two 4-bit beats on the four data lines, and the serial clock is derived from the system clock by a fixed divider. A read frame ends with two beats in which the block releases the lines and captures the target's reply. Chip select then rises, and a one-cycle completion pulse returns the read byte to the client.

Top module: `qspi_frame_master`

## Requirements
- R1: A frame carries the opcode byte, then address bits 23:16, 15:8 and 7:0, with each byte sent upper nibble first, and nibble bit i on `ioOut[i]`.
- R2: `reqOp` codes select the opcode: 2'd0 write sends 0x02, 2'd1 read sends 0x03, 2'd2 erase sends 0x20.
- R3: A write frame has 10 beats, ending with the two nibbles of `reqWdata`. An erase frame has 8 beats.
- R4: A read frame has 8 driven beats and then 2 beats with `ioOe` all zero. `ioIn` is sampled on those two rising SCLK edges, upper nibble first, and the byte appears on `rdata` in the cycle `done` is high.
- R5: `csN` is low for exactly beats×DIV system cycles per frame, covering every SCLK edge of the frame, and is high otherwise.
- R6: SCLK is low when idle. During a frame each beat lasts DIV cycles, low for DIV/2 cycles and then high. `ioOut` never changes while SCLK stays high.
- R7: A request is taken only when `busy` is low. A request made while `busy` is high is ignored and starts no later frame.
- R8: A request with `reqOp` = 2'd3 is ignored: `busy` stays low and `csN` stays high.
- R9: `done` is high for exactly one cycle, in the first idle cycle after a frame, with `busy` low. A request in that cycle is accepted, so `csN` stays high for exactly one cycle between the frames.
- R10: After reset `csN` is high, SCLK is low, `ioOe` is zero, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | Operation code: 0 write, 1 read, 2 erase, 3 none |
| reqAddr | input | 24 | Target address |
| reqWdata | input | 8 | Byte to write |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by a read frame |
| sclk | output | 1 | Serial clock, idles low |
| csN | output | 1 | Chip select, active low |
| ioOut | output | 4 | Data driven on the four lines |
| ioOe | output | 4 | Per-line output enable |
| ioIn | input | 4 | Data sampled from the four lines |

## Verification
The completion pulse of one frame and the acceptance of the next request can fall in the same cycle, because `busy` is already low while `done` is high. The bench provokes this by holding `reqValid` high through the end of a frame. It then requires `busy` low at the `done` cycle, `csN` low and `busy` high in the next cycle, and a second frame with the right beat count and contents. A separate test pulses a request while a frame is running and requires the finished frame to be unchanged and no frame to follow.

// File: rtl/qfm_pkg.sv
`timescale 1ns/1ps
package qfm_pkg;

  typedef enum logic [1:0] {
    REQ_WRITE = 2'd0,
    REQ_READ  = 2'd1,
    REQ_ERASE = 2'd2,
    REQ_NONE  = 2'd3
  } reqKind_t;

  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_ERASE = 8'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request fields into the frame register
    logic shift;    // advance to next outgoing nibble
    logic capture;  // sample incoming nibble
    logic driveEn;  // lines driven by this block
  } dpCtrl_t;

  function automatic logic [7:0] opcodeOf(input logic [1:0] kind);
    case (kind)
      REQ_WRITE: opcodeOf = OPC_WRITE;
      REQ_READ:  opcodeOf = OPC_READ;
      default:   opcodeOf = OPC_ERASE;
    endcase
  endfunction

endpackage

// File: rtl/qfm_ctrl.sv
`timescale 1ns/1ps
module qfm_ctrl
  import qfm_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int ADDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       busy,
  output logic       done,
  output logic       sclk,
  output logic       csN,
  output dpCtrl_t    dpCtrl
);

  localparam int DW       = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF     = DIV / 2;
  localparam int OUTB     = 2 * (1 + ADDR_BYTES);
  localparam int BEAT_MAX = OUTB + 2;
  localparam int BW       = $clog2(BEAT_MAX + 1);

  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] HALF_M1  = DW'(HALF - 1);
  localparam logic [DW-1:0] HALF_V   = DW'(HALF);
  localparam logic [BW-1:0] OUTB_V   = BW'(OUTB);

  typedef enum logic {ST_IDLE, ST_SHIFT} state_t;

  state_t        state;
  logic [DW-1:0] divCnt;
  logic [BW-1:0] beatCnt;
  logic [BW-1:0] lastBeat;
  logic          readFrame;

  logic accept, riseNext, fallNext, inReadBeats, lastEnd;

  always_comb begin
    accept      = (state == ST_IDLE) && reqValid && (reqOp != REQ_NONE);
    riseNext    = (state == ST_SHIFT) && (divCnt == HALF_M1);
    fallNext    = (state == ST_SHIFT) && (divCnt == DIV_LAST);
    inReadBeats = readFrame && (beatCnt >= OUTB_V);
    lastEnd     = fallNext && (beatCnt == lastBeat);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      beatCnt   <= '0;
      lastBeat  <= '0;
      readFrame <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_SHIFT;
            divCnt    <= '0;
            beatCnt   <= '0;
            readFrame <= (reqOp == REQ_READ);
            lastBeat  <= (reqOp == REQ_ERASE) ? BW'(OUTB - 1) : BW'(OUTB + 1);
          end
        end
        default: begin
          divCnt <= fallNext ? '0 : divCnt + 1'b1;
          if (lastEnd) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (fallNext) begin
            beatCnt <= beatCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    busy           = (state == ST_SHIFT);
    csN            = (state == ST_IDLE);
    sclk           = (state == ST_SHIFT) && (divCnt >= HALF_V);
    dpCtrl.load    = accept;
    dpCtrl.shift   = fallNext && !lastEnd;
    dpCtrl.capture = riseNext && inReadBeats;
    dpCtrl.driveEn = (state == ST_SHIFT) && !inReadBeats;
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R5
  cs_sclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastEnd) |=> (busy && $stable(lastBeat) && $stable(readFrame)));

  // R3
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (beatCnt <= lastBeat));

  // R8
  none_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqOp == REQ_NONE) |=> !busy);

endmodule

// File: rtl/qfm_datapath.sv
`timescale 1ns/1ps
module qfm_datapath
  import qfm_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 dpCtrl,
  input  logic [1:0]              reqOp,
  input  logic [8*ADDR_BYTES-1:0] reqAddr,
  input  logic [7:0]              reqWdata,
  input  logic [3:0]              ioIn,
  output logic [3:0]              ioOut,
  output logic [3:0]              ioOe,
  output logic [7:0]              rdata
);

  localparam int FRAME_W = 8 * (ADDR_BYTES + 2);

  logic [FRAME_W-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
    end else if (dpCtrl.load) begin
      frameReg <= {opcodeOf(reqOp), reqAddr, reqWdata};
    end else if (dpCtrl.shift) begin
      frameReg <= {frameReg[FRAME_W-5:0], 4'h0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (dpCtrl.capture) begin
      rdata <= {rdata[3:0], ioIn};
    end
  end

  always_comb begin
    ioOut = dpCtrl.driveEn ? frameReg[FRAME_W-1 -: 4] : 4'h0;
    ioOe  = {4{dpCtrl.driveEn}};
  end

  // R4
  capture_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.capture |-> (ioOe == 4'h0));

  // R1
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtrl.load && dpCtrl.shift));

endmodule

// File: rtl/qspi_frame_master.sv
`timescale 1ns/1ps
module qspi_frame_master
  import qfm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [23:0] reqAddr,
  input  logic [7:0]  reqWdata,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        sclk,
  output logic        csN,
  output logic [3:0]  ioOut,
  output logic [3:0]  ioOe,
  input  logic [3:0]  ioIn
);

  localparam int ADDR_BYTES = 3;

  dpCtrl_t dpCtrl;

  qfm_ctrl #(.DIV(DIV), .ADDR_BYTES(ADDR_BYTES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .busy     (busy),
    .done     (done),
    .sclk     (sclk),
    .csN      (csN),
    .dpCtrl   (dpCtrl)
  );

  qfm_datapath #(.ADDR_BYTES(ADDR_BYTES)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .ioIn     (ioIn),
    .ioOut    (ioOut),
    .ioOe     (ioOe),
    .rdata    (rdata)
  );

  // R6
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(ioOut));

  // R5
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (ioOe == 4'h0));

endmodule

// File: tb/qspi_frame_master_test.sv
`timescale 1ns/1ps
module qspi_frame_master_test;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [3:0]  ioIn = '0;
  logic        busy, done, sclk, csN;
  logic [7:0]  rdata;
  logic [3:0]  ioOut, ioOe;

  int checks = 0;
  int errors = 0;

  logic [3:0] capNib [16];
  logic [3:0] capOe  [16];
  int         capIdx = 0;
  int         csLowCnt = 0;
  int         stableErr = 0;
  logic [7:0] reply = 8'h00;
  logic       prevSclk = 1'b0;
  logic [3:0] prevOut = 4'h0;

  qspi_frame_master #(.DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdata(rdata), .sclk(sclk), .csN(csN), .ioOut(ioOut), .ioOe(ioOe),
    .ioIn(ioIn)
  );

  always #10 clk = ~clk;

  // target model: record each rising SCLK edge
  always @(posedge sclk) begin
    if (capIdx < 16) begin
      capNib[capIdx] = ioOut;
      capOe[capIdx]  = ioOe;
    end
    capIdx = capIdx + 1;
  end

  always @(negedge sclk) begin
    ioIn = (capIdx == 8) ? reply[7:4] : reply[3:0];
  end

  always @(negedge clk) begin
    if (!csN) csLowCnt = csLowCnt + 1;
    if (sclk && prevSclk && ioOut != prevOut) stableErr = stableErr + 1;
    prevSclk = sclk;
    prevOut  = ioOut;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishAll();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishAll();
  end

  function automatic logic [7:0] opOf(input logic [1:0] k);
    return (k == 2'd0) ? 8'h02 : (k == 2'd1) ? 8'h03 : 8'h20;
  endfunction

  function automatic logic [3:0] expNib(input logic [1:0] k, input logic [23:0] a,
                                        input logic [7:0] d, input int i);
    logic [39:0] f;
    f = {opOf(k), a, d};
    return f[39 - 4*i -: 4];
  endfunction

  task automatic issue(input logic [1:0] k, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    capIdx = 0; csLowCnt = 0; stableErr = 0;
    reqOp = k; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    int n;
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic judgeFrame(input string req, input logic [1:0] k, input logic [23:0] a,
                            input logic [7:0] d, input int beats);
    int outBeats;
    outBeats = (k == 2'd1) ? 8 : beats;
    check(done === 1'b1, "R9 done", done, 1);
    check(busy === 1'b0 && csN === 1'b1, "R9 idle at done", {busy, csN}, 2'b01);
    check(capIdx == beats, {req, " beat count"}, capIdx, beats);
    check(csLowCnt == beats * DIV, "R5 cs low cycles", csLowCnt, beats * DIV);
    check(stableErr == 0, "R6 out stable while sclk high", stableErr, 0);
    for (int i = 0; i < outBeats && i < 16; i++) begin
      check(capNib[i] === expNib(k, a, d, i) && capOe[i] === 4'hF,
            {req, " R1 nibble"}, {capOe[i], capNib[i]}, {4'hF, expNib(k, a, d, i)});
    end
  endtask

  task automatic t_reset();
    check(csN === 1'b1 && sclk === 1'b0, "R10 cs/sclk", {csN, sclk}, 2'b10);
    check(ioOe === 4'h0 && busy === 1'b0 && done === 1'b0, "R10 oe/busy/done",
          {ioOe, busy, done}, 0);
  endtask

  task automatic t_write();
    issue(2'd0, 24'h12A5C3, 8'h5A);
    check(busy === 1'b1 && csN === 1'b0, "R7 accepted", {busy, csN}, 2'b10);
    waitDone();
    judgeFrame("R2 R3 write", 2'd0, 24'h12A5C3, 8'h5A, 10);
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic t_erase();
    issue(2'd2, 24'hFEDCBA, 8'h77);
    waitDone();
    judgeFrame("R2 R3 erase", 2'd2, 24'hFEDCBA, 8'h77, 8);
  endtask

  task automatic t_read(input logic [23:0] a, input logic [7:0] r);
    reply = r;
    issue(2'd1, a, 8'h00);
    waitDone();
    judgeFrame("R2 R4 read", 2'd1, a, 8'h00, 10);
    check(capOe[8] === 4'h0 && capOe[9] === 4'h0, "R4 lines released",
          {capOe[8], capOe[9]}, 0);
    check(rdata === r, "R4 rdata", rdata, r);
  endtask

  task automatic t_busyIgnore();
    issue(2'd0, 24'h0A0B0C, 8'hC3);
    repeat (5) @(negedge clk);
    reqOp = 2'd1; reqAddr = 24'h999999; reqValid = 1'b1;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    waitDone();
    judgeFrame("R7 busy ignore", 2'd0, 24'h0A0B0C, 8'hC3, 10);
    repeat (3 * DIV) @(negedge clk);
    check(csN === 1'b1 && busy === 1'b0, "R7 no later frame", {csN, busy}, 2'b10);
  endtask

  task automatic t_badCode();
    @(negedge clk);
    capIdx = 0;
    reqOp = 2'd3; reqValid = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && csN === 1'b1, "R8 busy/cs", {busy, csN}, 2'b01);
    reqValid = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    check(capIdx == 0 && csN === 1'b1, "R8 no sclk", capIdx, 0);
  endtask

  task automatic t_backToBack();
    @(negedge clk);
    capIdx = 0; csLowCnt = 0; stableErr = 0;
    reqOp = 2'd2; reqAddr = 24'h135724; reqValid = 1'b1;
    waitDone();
    judgeFrame("R9 first", 2'd2, 24'h135724, 8'h00, 8);
    capIdx = 0; csLowCnt = 0; stableErr = 0;
    @(negedge clk);
    reqValid = 1'b0;
    check(csN === 1'b0 && busy === 1'b1, "R9 accepted on done cycle", {csN, busy}, 2'b01);
    waitDone();
    judgeFrame("R9 second", 2'd2, 24'h135724, 8'h00, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_erase();
    t_read(24'h00F00F, 8'hA5);
    t_read(24'h800001, 8'h3C);
    t_busyIgnore();
    t_badCode();
    t_backToBack();
    repeat (4) @(negedge clk);
    finishAll();
  end

endmodule